// File: doc/BRIEF.md
# GPIO Bank with Per-Pin Interrupt Detection

This block is a bank of general-purpose pins on a simple register bus. Every pin can be an input or an output, and it can also be an interrupt source. Software places a pin in output mode and sets the level it drives, or it reads back the pin's synchronised input level. Each pin also has its own event detector. That detector can watch for a single edge or for a level, and the polarity can be chosen.

Two independent gates act on each pin's event. One decides whether the event is recorded in a sticky status bit. The other decides whether the event raises the pin's interrupt. A per-pin routing code then decides whether that interrupt reaches the one summary interrupt line. Catching both edges is left to software, which flips the polarity bit after each event.

Top module: `gpio_irq_bank`

## Requirements
- R1: After reset, every output enable, driven value, interrupt configuration and status bit is 0. Every routing code reads 7, and `summary_irq` is 0.
- R2: The per-pin group of pin n starts at byte offset 0x1000 + 0x10·n. Bit 9 of the word at +0x0 is the output enable. Bit 1 of the word at +0x4 is the driven value. `pad_oe[n]` and `pad_out[n]` follow a write on the next clock edge and change at no other time.
- R3: Bit 0 of the word at +0x4 reads the pin input after a two-flop synchroniser. Read data appears on `rdata` one clock edge after `rd_en` and holds between reads.
- R4: The interrupt configuration word is at +0x8. Its bits are: bit 0 interrupt enable, bit 1 polarity, bit 2 detection mode, bit 3 status-record enable. With bit 2 = 1, a rising edge (polarity 1) or a falling edge (polarity 0) is an event. The pending interrupt it creates stays set until status is cleared.
- R5: With bit 2 = 0, the event is the input being high (polarity 1) or low (polarity 0). The pin interrupt follows the synchronised level.
- R6: Bit 0 of the word at +0xC is a sticky status bit. An event sets it only when the status-record enable is 1. Writing 1 to it clears it, but an event in the same cycle takes priority over the clear.
- R7: The interrupt enable gates the interrupt independently of the status bit. An interrupt can fire while status stays 0, and status can be set while no interrupt fires.
- R8: The routing code of pin n is bits 2:0 at offset 0x400 + 4·n. `summary_irq` is the OR of every pin interrupt whose routing code is 4. Any other code routes the pin nowhere.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | AW | Byte address |
| wdata | input | DW | Write data |
| rdata | output | DW | Read data, registered |
| pad_in | input | NPIN | Pin input levels, asynchronous |
| pad_out | output | NPIN | Driven pin values |
| pad_oe | output | NPIN | Pin output enables |
| summary_irq | output | 1 | Combined routed interrupt |

## Verification
Each result has its own delay after the stimulus:

| Result | Due after |
|---|---|
| Register write reaching `pad_oe` or `pad_out` | one clock edge |
| Read data on `rdata` | the edge after the `rd_en` cycle |
| Input level readable, level interrupt on `summary_irq` | two edges after a pin change |
| Edge pending, and either kind of status | three edges after a pin change |

The scoreboard pops each expected read word on the falling edge that follows the capture edge. Pin-level results are sampled on a falling edge four cycles after the pin moves, which covers the longest of these paths. Checks made after a status clear are sampled on the falling edge right after the write edge, so they also confirm that the interrupt drops within one edge of the clear.

// File: rtl/gpio_irq_bank.sv
module gpio_irq_bank #(
  parameter int NPIN = 8,
  parameter int AW   = 13,
  parameter int DW   = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_en,
  input  logic            rd_en,
  input  logic [AW-1:0]   addr,
  input  logic [DW-1:0]   wdata,
  output logic [DW-1:0]   rdata,
  input  logic [NPIN-1:0] pad_in,
  output logic [NPIN-1:0] pad_out,
  output logic [NPIN-1:0] pad_oe,
  output logic            summary_irq
);
  localparam logic [2:0] ROUTE_APP  = 3'd4;
  localparam logic [2:0] ROUTE_NONE = 3'd7;
  localparam int IDX_W = AW - 5;

  logic [NPIN-1:0] sync1, sync2, prev;
  logic [NPIN-1:0][3:0] icfg;
  logic [NPIN-1:0][2:0] route;
  logic [NPIN-1:0] stat_q, pend_q, pin_irq, grp_hit, rt_hit;
  logic [DW-1:0] rd_mux;

  wire grp_sel = addr[AW-1];
  wire [IDX_W-1:0] grp_idx = addr[AW-2:4];
  wire [1:0] reg_sel = addr[3:2];
  wire rt_sel = (addr[AW-1:10] == 'd1);
  wire [7:0] rt_idx = addr[9:2];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      sync1 <= '0; sync2 <= '0; prev <= '0;
    end else begin
      sync1 <= pad_in; sync2 <= sync1; prev <= sync2;
    end

  for (genvar i = 0; i < NPIN; i++) begin : g_pin
    assign grp_hit[i] = grp_sel && (grp_idx == IDX_W'(i));
    assign rt_hit[i]  = rt_sel && (rt_idx == 8'(i));

    wire pol      = icfg[i][1];
    wire edge_md  = icfg[i][2];
    wire edge_evt = pol ? (sync2[i] & ~prev[i]) : (~sync2[i] & prev[i]);
    wire lvl_act  = pol ? sync2[i] : ~sync2[i];
    wire evt      = edge_md ? edge_evt : lvl_act;
    wire clr      = wr_en && grp_hit[i] && reg_sel == 2'd3 && wdata[0];

    assign pin_irq[i] = icfg[i][0] & (edge_md ? pend_q[i] : lvl_act);

    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) begin
        pad_oe[i]  <= 1'b0;
        pad_out[i] <= 1'b0;
        icfg[i]    <= '0;
        route[i]   <= ROUTE_NONE;
        stat_q[i]  <= 1'b0;
        pend_q[i]  <= 1'b0;
      end else begin
        if (wr_en && grp_hit[i]) begin
          if (reg_sel == 2'd0) pad_oe[i]  <= wdata[9];
          if (reg_sel == 2'd1) pad_out[i] <= wdata[1];
          if (reg_sel == 2'd2) icfg[i]    <= wdata[3:0];
        end
        if (wr_en && rt_hit[i]) route[i] <= wdata[2:0];
        stat_q[i] <= (stat_q[i] & ~clr) | (evt & icfg[i][3]);
        pend_q[i] <= (pend_q[i] & ~clr) | (edge_md & edge_evt & icfg[i][0]);
      end
  end

  always_comb begin
    rd_mux = '0;
    summary_irq = 1'b0;
    for (int i = 0; i < NPIN; i++) begin
      if (route[i] == ROUTE_APP) summary_irq = summary_irq | pin_irq[i];
      if (grp_hit[i]) begin
        case (reg_sel)
          2'd0: rd_mux[9]   = pad_oe[i];
          2'd1: rd_mux[1:0] = {pad_out[i], sync2[i]};
          2'd2: rd_mux[3:0] = icfg[i];
          default: rd_mux[0] = stat_q[i];
        endcase
      end
      if (rt_hit[i]) rd_mux[2:0] = route[i];
    end
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) rdata <= '0;
    else if (rd_en) rdata <= rd_mux;
endmodule

// File: rtl/gpio_irq_bank_checker.sv
module gpio_irq_bank_checker #(
  parameter int NPIN = 8,
  parameter int DW   = 32
) (
  input logic            clk,
  input logic            rst_n,
  input logic            wr_en,
  input logic            rd_en,
  input logic [DW-1:0]   rdata,
  input logic [NPIN-1:0] pad_oe,
  input logic [NPIN-1:0] pad_out,
  input logic [NPIN-1:0] stat_q,
  input logic [NPIN-1:0] pin_irq,
  input logic            summary_irq
);
  p_oe_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(wr_en) |-> $stable(pad_oe));
  p_out_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(wr_en) |-> $stable(pad_out));
  p_rdata_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(rd_en) |-> $stable(rdata));
  p_status_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(wr_en) |-> (($past(stat_q) & ~stat_q) == '0));
  p_summary_src_r8: assert property (@(posedge clk) disable iff (!rst_n)
    summary_irq |-> (pin_irq != '0));
endmodule

bind gpio_irq_bank gpio_irq_bank_checker #(.NPIN(NPIN), .DW(DW)) u_checker (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .rdata(rdata),
  .pad_oe(pad_oe), .pad_out(pad_out), .stat_q(stat_q), .pin_irq(pin_irq),
  .summary_irq(summary_irq));

// File: tb/gpio_irq_bank_bench.sv
module gpio_irq_bank_bench;
  localparam int NPIN = 8, AW = 13, DW = 32;
  logic clk = 0, rst_n = 0, wr_en = 0, rd_en = 0;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] wdata = '0, rdata;
  logic [NPIN-1:0] pad_in = '0, pad_out, pad_oe;
  logic summary_irq;
  int n_run = 0, n_fail = 0;
  logic rd_seen = 0;
  logic [DW-1:0] exp_q[$];
  string tag_q[$];

  gpio_irq_bank #(.NPIN(NPIN), .AW(AW), .DW(DW)) u_gpio_irq_bank (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .pad_in(pad_in), .pad_out(pad_out),
    .pad_oe(pad_oe), .summary_irq(summary_irq));

  always #4 clk = ~clk;

  function automatic logic [AW-1:0] a_grp(int pin, int off);
    return AW'(32'h1000 + 16 * pin + off);
  endfunction
  function automatic logic [AW-1:0] a_rt(int pin);
    return AW'(32'h400 + 4 * pin);
  endfunction

  task automatic chk(bit ok, string tag, int act, int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [AW-1:0] a, logic [DW-1:0] d);
    @(negedge clk); wr_en = 1; addr = a; wdata = d;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic rd(logic [AW-1:0] a, logic [DW-1:0] exp, string tag);
    @(negedge clk); rd_en = 1; addr = a;
    exp_q.push_back(exp); tag_q.push_back(tag);
    @(negedge clk); rd_en = 0;
  endtask

  task automatic settle();
    repeat (4) @(negedge clk);
  endtask

  always @(posedge clk) rd_seen <= rd_en;
  always @(negedge clk)
    if (rd_seen && exp_q.size() > 0) begin
      logic [DW-1:0] e;
      string t;
      e = exp_q.pop_front(); t = tag_q.pop_front();
      chk(rdata == e, t, int'(rdata), int'(e));
    end

  initial begin
    #(8 * 150000);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(pad_oe == 0 && pad_out == 0, "R1 pads after reset", int'({pad_oe, pad_out}), 0);
    chk(summary_irq == 0, "R1 summary after reset", int'(summary_irq), 0);
    rd(a_rt(3), 7, "R1 route reset code");
    rd(a_grp(5, 12), 0, "R1 status reset");

    wr(a_grp(1, 0), 32'h200);
    chk(pad_oe == 8'h02, "R2 output enable", int'(pad_oe), 2);
    wr(a_grp(1, 4), 32'h2);
    chk(pad_out == 8'h02, "R2 driven value", int'(pad_out), 2);
    rd(a_grp(1, 0), 32'h200, "R2 config readback");

    pad_in[2] = 1; settle();
    rd(a_grp(2, 4), 1, "R3 input level readback");
    rd(a_grp(1, 4), 2, "R3 io readback output bit");

    wr(a_grp(3, 8), 32'hF); wr(a_rt(3), 4);
    rd(a_rt(3), 4, "R8 route readback");
    pad_in[3] = 1; settle();
    chk(summary_irq == 1, "R4 rising edge interrupt", int'(summary_irq), 1);
    rd(a_grp(3, 12), 1, "R6 status on edge");
    pad_in[3] = 0; settle();
    chk(summary_irq == 1, "R4 edge pending after input falls", int'(summary_irq), 1);
    wr(a_grp(3, 12), 1);
    chk(summary_irq == 0, "R4 pending cleared by status write", int'(summary_irq), 0);
    rd(a_grp(3, 12), 0, "R6 write one clears status");
    wr(a_rt(3), 7);

    wr(a_grp(4, 8), 32'h7); wr(a_rt(4), 4);
    pad_in[4] = 1; settle();
    chk(summary_irq == 1, "R7 interrupt without status record", int'(summary_irq), 1);
    rd(a_grp(4, 12), 0, "R6 record enable off keeps status clear");
    wr(a_grp(4, 12), 1);
    chk(summary_irq == 0, "R7 clear drops interrupt", int'(summary_irq), 0);
    wr(a_rt(4), 7);

    wr(a_grp(5, 8), 32'hE); wr(a_rt(5), 4);
    pad_in[5] = 1; settle();
    chk(summary_irq == 0, "R7 interrupt enable off", int'(summary_irq), 0);
    rd(a_grp(5, 12), 1, "R7 status set with interrupt off");
    wr(a_grp(5, 12), 1); wr(a_rt(5), 7);

    wr(a_grp(6, 8), 32'hF);
    pad_in[6] = 1; settle();
    chk(summary_irq == 0, "R8 route code 7 blocks summary", int'(summary_irq), 0);
    rd(a_grp(6, 12), 1, "R8 status still recorded");
    wr(a_grp(6, 12), 1);

    pad_in[0] = 1; settle();
    wr(a_grp(0, 8), 32'hD); wr(a_rt(0), 4);
    chk(summary_irq == 0, "R4 no event while high", int'(summary_irq), 0);
    pad_in[0] = 0; settle();
    chk(summary_irq == 1, "R4 falling edge interrupt", int'(summary_irq), 1);
    wr(a_grp(0, 12), 1); wr(a_rt(0), 7);
    chk(summary_irq == 0, "R4 falling pin cleared", int'(summary_irq), 0);

    pad_in[7] = 1; settle();
    wr(a_grp(7, 8), 32'h9); wr(a_rt(7), 4);
    chk(summary_irq == 0, "R5 level low inactive when high", int'(summary_irq), 0);
    pad_in[7] = 0; settle();
    chk(summary_irq == 1, "R5 level low active", int'(summary_irq), 1);
    wr(a_grp(7, 12), 1);
    rd(a_grp(7, 12), 1, "R6 event beats clear");
    pad_in[7] = 1; settle();
    chk(summary_irq == 0, "R5 level interrupt follows input", int'(summary_irq), 0);
    rd(a_grp(7, 12), 1, "R6 status sticky after level ends");
    wr(a_grp(7, 12), 1);
    rd(a_grp(7, 12), 0, "R6 level status cleared");

    repeat (2) @(negedge clk);
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule